// File: doc/BRIEF.md
# Reference Clock Rate Supervisor

This block decides whether an asynchronous reference clock is fast enough for a frequency synthesizer to run. A free-running housekeeping clock of known frequency times a fixed measurement window. The reference is brought into that domain by a multi-flop synchronizer and a rising-edge detector, and the edges are counted over the window. When a window closes, the count is compared with a minimum edge count. That minimum is worked out at elaboration time from the lowest allowed reference rate, the window length and the housekeeping frequency. The lowest allowed rate is 1 MHz when the clock multiplier is off and 5 MHz when it is on.

If the count is short, the block forces the synthesizer into power-down and also drops the enable of an auxiliary comparator. A reference that stops completely is treated the same way. Once a window passes the check again, power-down is held for a fixed resume time of about 5 µs before it is released. If a window fails during that wait, the wait starts over. A synchronous, active-high reset places the block in forced power-down until the first full window has been judged and the resume time has passed.

Top module: `refclk_loss_monitor`

## Requirements
- R1: While reset is high and after it is released, `pwr_down_o` is 1 and `cmp_en_o` is 0. They stay that way until the first window has closed with a passing count and the resume delay has then run out. The first window closes WINDOW_CYCLES clock edges after reset is released.
- R2: With `mult_en_i` = 0, a window passes when its count of reference rising edges is at least floor(MIN_DIRECT_HZ × WINDOW_CYCLES / HK_FREQ_HZ), raised to 1 if it comes out as 0. With the defaults this is 4 edges. A 2 MHz or 4 MHz reference keeps the block running.
- R3: With `mult_en_i` = 1, the minimum uses MIN_MULT_HZ instead (20 edges with the defaults). A 2 MHz reference forces power-down and a 6 MHz reference runs. The level of `mult_en_i` is taken at each window close, so changing it needs no reset.
- R4: A window that closes with a count below the active minimum sets `pwr_down_o` to 1 on the clock edge that closes it. This holds in every state, including 4 MHz with the multiplier on and 0.5 MHz with it off.
- R5: A reference that stops entirely (zero edges in a window) counts as below the minimum and forces power-down.
- R6: `cmp_en_o` is always the inverse of `pwr_down_o`.
- R7: After a window closes with a passing count while the block is powered down, `pwr_down_o` falls exactly RESUME_CYCLES = floor(RESUME_NS × HK_FREQ_HZ / 1e9) edges later (1250 with the defaults). From a failing window close to release this is WINDOW_CYCLES + RESUME_CYCLES edges.
- R8: A failing window that closes during the resume delay cancels it. The next passing window starts a full new delay of RESUME_CYCLES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running housekeeping clock of HK_FREQ_HZ |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk_i | input | 1 | Reference clock under supervision, asynchronous to `clk` |
| mult_en_i | input | 1 | Clock multiplier enabled; selects the higher minimum rate |
| pwr_down_o | output | 1 | Forced power-down request to the synthesizer |
| cmp_en_o | output | 1 | Auxiliary comparator enable, low while powered down |

## Verification
Power-down goes high on the edge that closes a failing window. Release comes exactly RESUME_CYCLES edges after a passing window closes. From a failing close this is WINDOW_CYCLES + RESUME_CYCLES edges, and from reset release it is the same sum. The bench cannot see window boundaries directly, so it finds one by watching `pwr_down_o` rise after the reference is stopped. It then counts negative clock edges from that point and samples one cycle before and exactly at the expected release, which checks the delay to the cycle. Checks on rate and threshold sit at least three windows after each stimulus (plus the resume time where a release is expected), so the phase of a window never decides their outcome.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef enum logic [1:0] {
    ST_HOLD   = 2'd0,
    ST_RESUME = 2'd1,
    ST_RUN    = 2'd2
  } refmon_state_e;

  // Minimum edge count per window for a given lowest rate; never below one,
  // so that a stopped reference always fails.
  function automatic int min_edges(input longint rate_hz, input longint win_cycles,
                                   input longint hk_hz);
    longint q;
    q = (rate_hz * win_cycles) / hk_hz;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  // Resume hold time in housekeeping cycles; at least one.
  function automatic int resume_cycles(input longint hold_ns, input longint hk_hz);
    longint q;
    q = (hold_ns * hk_hz) / 64'd1_000_000_000;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  output logic edge_pulse_o
);

  logic [STAGES-1:0] stg_q;
  logic              prev_q;
  logic              pulse_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q[0] <= 1'b0;
    else     stg_q[0] <= ref_clk_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[i] <= 1'b0;
      else     stg_q[i] <= stg_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= stg_q[STAGES-1];
      pulse_q <= stg_q[STAGES-1] & ~prev_q;
    end
  end

  assign edge_pulse_o = pulse_q;

  // A rising edge detector never reports two edges on consecutive cycles.
  AST_PULSE_ONESHOT: assert property (@(posedge clk) disable iff (rst)
    edge_pulse_o |=> !edge_pulse_o); // R2

endmodule

// File: rtl/refmon_rate_window.sv
module refmon_rate_window #(
  parameter int WINDOW_CYCLES = 1024,
  parameter int THR_DIRECT    = 4,
  parameter int THR_MULT      = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_pulse_i,
  input  logic mult_en_i,
  output logic win_done_o,
  output logic rate_low_o
);

  localparam int WIN_W  = $clog2(WINDOW_CYCLES);
  localparam int EDGE_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [WIN_W-1:0]  WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);
  localparam logic [EDGE_W-1:0] EDGE_MAX = EDGE_W'(WINDOW_CYCLES);

  logic [WIN_W-1:0]  win_cnt_q;
  logic [EDGE_W-1:0] edge_cnt_q;
  logic [31:0]       thr_sel;
  logic [31:0]       cnt_ext;

  assign win_done_o = (win_cnt_q == WIN_LAST);
  assign thr_sel    = mult_en_i ? 32'(THR_MULT) : 32'(THR_DIRECT);
  assign cnt_ext    = 32'(edge_cnt_q);
  assign rate_low_o = (cnt_ext < thr_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt_q <= '0;
    end else if (win_done_o) begin
      win_cnt_q <= '0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt_q <= '0;
    end else if (win_done_o) begin
      edge_cnt_q <= '0;
    end else if (edge_pulse_i && (edge_cnt_q != EDGE_MAX)) begin
      edge_cnt_q <= edge_cnt_q + 1'b1;
    end
  end

  // Window closes are isolated events, one per window.
  AST_WIN_SPACING: assert property (@(posedge clk) disable iff (rst)
    win_done_o |=> !win_done_o); // R4

  // Every window starts counting from zero, so a stopped reference reads zero.
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    win_done_o |=> (edge_cnt_q == '0)); // R5

endmodule

// File: rtl/refmon_resume_ctrl.sv
module refmon_resume_ctrl
  import refmon_pkg::*;
#(
  parameter int RESUME_CYCLES = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic win_done_i,
  input  logic rate_low_i,
  output logic pwr_down_o,
  output logic cmp_en_o
);

  localparam int RES_W = $clog2(RESUME_CYCLES + 1);
  localparam logic [RES_W-1:0] RES_LOAD = RES_W'(RESUME_CYCLES - 1);

  refmon_state_e    state_q;
  logic [RES_W-1:0] dly_q;
  logic             fail_close;
  logic             pass_close;

  assign fail_close = win_done_i & rate_low_i;
  assign pass_close = win_done_i & ~rate_low_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HOLD;
      dly_q   <= '0;
    end else if (fail_close) begin
      state_q <= ST_HOLD;
      dly_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (pass_close) begin
            state_q <= ST_RESUME;
            dly_q   <= RES_LOAD;
          end
        end
        ST_RESUME: begin
          if (dly_q == '0) state_q <= ST_RUN;
          else             dly_q   <= dly_q - 1'b1;
        end
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign pwr_down_o = (state_q != ST_RUN);
  assign cmp_en_o   = (state_q == ST_RUN);

  AST_RESET_HOLD: assert property (@(posedge clk)
    rst |=> pwr_down_o); // R1

  AST_LOW_FORCES_PD: assert property (@(posedge clk) disable iff (rst)
    fail_close |=> (pwr_down_o && state_q == ST_HOLD)); // R4

  AST_CMP_TRACKS_PD: assert property (@(posedge clk) disable iff (rst)
    cmp_en_o != pwr_down_o); // R6

  AST_RESUME_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && pass_close) |=> (state_q == ST_RESUME && dly_q == RES_LOAD)); // R7

  AST_RELEASE_AFTER_DELAY: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_down_o) |-> $past(state_q == ST_RESUME && dly_q == '0)); // R7

  AST_DELAY_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESUME && fail_close) |=> (state_q == ST_HOLD)); // R8

endmodule

// File: rtl/refclk_loss_monitor.sv
module refclk_loss_monitor #(
  parameter int HK_FREQ_HZ    = 250_000_000,
  parameter int WINDOW_CYCLES = 1024,
  parameter int MIN_DIRECT_HZ = 1_000_000,
  parameter int MIN_MULT_HZ   = 5_000_000,
  parameter int RESUME_NS     = 5000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_clk_i,
  input  logic mult_en_i,
  output logic pwr_down_o,
  output logic cmp_en_o
);

  localparam int THR_DIRECT = refmon_pkg::min_edges(MIN_DIRECT_HZ, WINDOW_CYCLES, HK_FREQ_HZ);
  localparam int THR_MULT   = refmon_pkg::min_edges(MIN_MULT_HZ, WINDOW_CYCLES, HK_FREQ_HZ);
  localparam int RES_CYC    = refmon_pkg::resume_cycles(RESUME_NS, HK_FREQ_HZ);

  logic edge_pulse;
  logic win_done;
  logic rate_low;

  refmon_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk          (clk),
    .rst          (rst),
    .ref_clk_i    (ref_clk_i),
    .edge_pulse_o (edge_pulse)
  );

  refmon_rate_window #(
    .WINDOW_CYCLES (WINDOW_CYCLES),
    .THR_DIRECT    (THR_DIRECT),
    .THR_MULT      (THR_MULT)
  ) u_window (
    .clk          (clk),
    .rst          (rst),
    .edge_pulse_i (edge_pulse),
    .mult_en_i    (mult_en_i),
    .win_done_o   (win_done),
    .rate_low_o   (rate_low)
  );

  refmon_resume_ctrl #(
    .RESUME_CYCLES (RES_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .win_done_i (win_done),
    .rate_low_i (rate_low),
    .pwr_down_o (pwr_down_o),
    .cmp_en_o   (cmp_en_o)
  );

endmodule

// File: tb/refclk_loss_monitor_tb_top.sv
`timescale 1ns/1ps
module refclk_loss_monitor_tb_top;

  localparam int CLK_NS  = 4;
  localparam int WIN     = 1024;
  // Resume hold: 5000 ns at a 4 ns period.
  localparam int RES     = 5000 / CLK_NS;
  // Minimum edges per window: window length in ns divided by the slowest period.
  localparam int MIN_DIR = (WIN * CLK_NS) / 1000;
  localparam int MIN_MUL = (WIN * CLK_NS) / 200;

  typedef struct {
    string req;
    bit    exp_pd;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk = 1'b0;
  logic mult_en = 1'b0;
  logic pwr_down;
  logic cmp_en;
  int   ref_half_ns = 50;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_item_t sb_q[$];
  event sample_ev;

  always #(CLK_NS/2) clk = ~clk;

  always begin
    if (ref_half_ns == 0) begin
      ref_clk = 1'b0;
      #4;
    end else begin
      #(ref_half_ns) ref_clk = ~ref_clk;
    end
  end

  refclk_loss_monitor dut_i (
    .clk        (clk),
    .rst        (rst),
    .ref_clk_i  (ref_clk),
    .mult_en_i  (mult_en),
    .pwr_down_o (pwr_down),
    .cmp_en_o   (cmp_en)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_pd(input string req, input bit pd);
    exp_item_t it;
    it.req    = req;
    it.exp_pd = pd;
    sb_q.push_back(it);
    -> sample_ev;
    #0;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (pwr_down !== it.exp_pd) begin
        n_fail++;
        $display("FAIL %s pwr_down actual=%b expected=%b at %0t", it.req, pwr_down, it.exp_pd, $time);
      end
      n_checks++;
      if (cmp_en !== !it.exp_pd) begin
        n_fail++;
        $display("FAIL R6 cmp_en actual=%b expected=%b at %0t", cmp_en, !it.exp_pd, $time);
      end
    end
  endtask

  // Monitor: compares ports against queued expectations.
  initial begin
    forever begin
      @(sample_ev);
      drain();
    end
  end

  task automatic wait_rise();
    for (int i = 0; i < 4 * WIN && pwr_down !== 1'b1; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    $display("window=%0d resume=%0d min_direct=%0d min_mult=%0d", WIN, RES, MIN_DIR, MIN_MUL);
    wait_cyc(5);
    expect_pd("R1", 1'b1);
    rst = 1'b0;
    // First close after WIN edges, release RES edges later.
    wait_cyc(WIN + RES - 1);
    expect_pd("R1", 1'b1);
    wait_cyc(1);
    expect_pd("R7", 1'b0);

    // 2 MHz, multiplier off: about 8 edges, minimum 4.
    ref_half_ns = 250;
    wait_cyc(3 * WIN);
    expect_pd("R2", 1'b0);

    // 2 MHz, multiplier on: minimum 20.
    mult_en = 1'b1;
    wait_cyc(3 * WIN);
    expect_pd("R3", 1'b1);

    // 6 MHz, multiplier on: about 24 edges.
    ref_half_ns = 83;
    wait_cyc(3 * WIN + RES);
    expect_pd("R3", 1'b0);

    // 4 MHz, multiplier on: about 16 edges, below 20.
    ref_half_ns = 125;
    wait_cyc(3 * WIN);
    expect_pd("R4", 1'b1);

    // 4 MHz, multiplier off: passes.
    mult_en = 1'b0;
    wait_cyc(3 * WIN + RES);
    expect_pd("R2", 1'b0);

    // 0.5 MHz, multiplier off: 2 edges, below 4.
    ref_half_ns = 1000;
    wait_cyc(3 * WIN);
    expect_pd("R4", 1'b1);

    ref_half_ns = 50;
    wait_cyc(3 * WIN + RES);
    expect_pd("R2", 1'b0);

    // Stopped reference; the rise marks a window close.
    ref_half_ns = 0;
    wait_rise();
    expect_pd("R5", 1'b1);
    ref_half_ns = 50;
    wait_cyc(WIN + RES - 1);
    expect_pd("R7", 1'b1);
    wait_cyc(1);
    expect_pd("R7", 1'b0);

    // Failing window during the resume delay restarts it.
    ref_half_ns = 0;
    wait_rise();
    expect_pd("R5", 1'b1);
    ref_half_ns = 50;
    wait_cyc(WIN + 10);
    ref_half_ns = 0;
    wait_cyc(RES - 5);
    expect_pd("R8", 1'b1);
    ref_half_ns = 50;
    wait_cyc(2 * WIN - 6);
    expect_pd("R8", 1'b1);
    wait_cyc(1);
    expect_pd("R8", 1'b0);

    // Reset in the running state forces power-down again.
    wait_cyc(10);
    rst = 1'b1;
    wait_cyc(2);
    expect_pd("R1", 1'b1);
    rst = 1'b0;
    wait_cyc(WIN - 2);
    expect_pd("R1", 1'b1);

    done = 1'b1;
    wait_cyc(2);
    finish_run();
  end

endmodule